// File: doc/BRIEF.md
# CAN Bus Fault Qualifier and Latch

This block turns raw short-circuit indications from the analog side of a CAN transceiver into latched interrupt flags. There is one raw input for each short type. The block watches the transmit data line and measures each dominant bit in cycles of its timebase clock. A short is confirmed only when it is present at enough dominant-to-recessive edges that follow a long enough dominant bit. Confirmed shorts set flags in one status byte. Software clears a flag by writing a one to its bit. An active-low wired fault output is pulled low while any flag is set.

A mode input picks one of two clearing policies. In software-clear mode, a flag stays latched until the short has gone and a one is written to its bit. In auto-clear mode, a flag also drops after a run of clean qualifying edges, or when the device leaves normal mode.

The transmit line is classified by a three-state machine:
- `ST_RECESSIVE` moves to `ST_DOM_SHORT` when the line goes dominant.
- `ST_DOM_SHORT` moves to `ST_DOM_LONG` once the dominant time reaches the minimum. It returns to `ST_RECESSIVE` on a recessive sample and emits a short edge.
- `ST_DOM_LONG` returns to `ST_RECESSIVE` on a recessive sample and emits a qualifying edge.

Each fault channel is a two-state machine:
- `CH_CLEAR` moves to `CH_LATCHED` on a confirming edge.
- `CH_LATCHED` moves back to `CH_CLEAR` on an accepted clear, a clean-run clear or a leave-normal clear.

Top module: `busflt_monitor`

## Requirements
- R1: After reset, `status` reads 0x00 and `fault_n` is 1.
- R2: A dominant-to-recessive edge qualifies only if `txd` was low (dominant) for at least `TICKS_PER_US*MIN_DOM_US` clock cycles before it (8 with the defaults). An edge after a shorter dominant bit never advances any count and restarts all qualification progress.
- R3: A flag sets when its raw input is high at 4 consecutive qualifying edges. It becomes visible in the cycle after the fourth edge is sampled. Three such edges do not set it.
- R4: A qualifying edge with the raw input low restarts that channel's detection count.
- R5: Status bit positions are: bit 0 CANL short to supply, bit 1 CANL short to ground, bit 2 CANH short to supply, bit 3 CANH short to ground, bit 4 CANH-to-CANL short. Bits 7:5 read 0. `flt_raw` uses the same bit order.
- R6: A write with `wr_en` high clears each set flag whose `wr_data` bit is 1 while its raw input is low. A 0 bit in `wr_data` has no effect.
- R7: A one-write to a flag whose raw input is high leaves the flag at 1.
- R8: With `auto_clr` low, flags are never cleared by clean edges or by leaving normal mode.
- R9: With `auto_clr` high, a set flag clears after 4 consecutive qualifying edges with its raw input low.
- R10: With `auto_clr` high, all flags clear in the cycle after `normal_mode` falls.
- R11: `fault_n` is 0 exactly when `normal_mode` is 1 and at least one flag is set. Otherwise it is 1.
- R12: While `normal_mode` is 0, edges do not advance detection. Counts restart from zero when normal mode is entered again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txd | input | 1 | Transmit data, 0 = dominant, 1 = recessive |
| normal_mode | input | 1 | 1 while the device is in normal mode |
| auto_clr | input | 1 | 1 selects auto-clear, 0 selects software-clear |
| flt_raw | input | 5 | Raw short indications, one per fault type |
| wr_en | input | 1 | Write strobe for the status byte |
| wr_data | input | 8 | Write-one-to-clear mask |
| status | output | 8 | Latched fault flags |
| fault_n | output | 1 | Active-low fault indication |

## Verification
Dominant bits are driven at one cycle below the minimum, at exactly the minimum, and well above it. This separates an off-by-one in the timer from a qualification that ignores bit length. Fault patterns that persist for three, four and more edges, or that vanish in between, separate the detection threshold from the restart behaviour. Clear writes are issued with the raw input both present and absent, in both policies and across mode changes. These writes distinguish a blocked clear, an accepted clear and automatic clearing. A seeded random mix of all of these checks the flag byte and fault output against a behavioural model after every operation.

// File: rtl/busflt_pkg.sv
package busflt_pkg;

    typedef enum logic [1:0] {
        ST_RECESSIVE = 2'd0,
        ST_DOM_SHORT = 2'd1,
        ST_DOM_LONG  = 2'd2
    } txd_state_t;

    typedef enum logic {
        CH_CLEAR   = 1'b0,
        CH_LATCHED = 1'b1
    } chan_state_t;

    localparam int FLT_TYPES   = 5;
    localparam int IDX_L_SUP   = 0;
    localparam int IDX_L_GND   = 1;
    localparam int IDX_H_SUP   = 2;
    localparam int IDX_H_GND   = 3;
    localparam int IDX_H_L     = 4;

endpackage

// File: rtl/busflt_edge_fsm.sv
module busflt_edge_fsm
    import busflt_pkg::*;
#(
    parameter int MIN_DOM_TICKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic txd,
    output logic qual_edge,
    output logic short_edge
);

    localparam int TMR_W = $clog2(MIN_DOM_TICKS + 1);
    localparam logic [TMR_W-1:0] TMR_MAX = TMR_W'(MIN_DOM_TICKS);

    txd_state_t state_q, state_d;
    logic [TMR_W-1:0] tmr_q;
    logic             reach_min;

    // dominant time (including the current sample) reaches the minimum
    assign reach_min = (int'(tmr_q) + 1) >= MIN_DOM_TICKS;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RECESSIVE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else if (txd) begin
            tmr_q <= '0;
        end else if (tmr_q != TMR_MAX) begin
            tmr_q <= tmr_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RECESSIVE: begin
                if (!txd) begin
                    state_d = (MIN_DOM_TICKS <= 1) ? ST_DOM_LONG : ST_DOM_SHORT;
                end
            end
            ST_DOM_SHORT: begin
                if (txd) begin
                    state_d = ST_RECESSIVE;
                end else if (reach_min) begin
                    state_d = ST_DOM_LONG;
                end
            end
            ST_DOM_LONG: begin
                if (txd) begin
                    state_d = ST_RECESSIVE;
                end
            end
            default: state_d = ST_RECESSIVE;
        endcase
    end

    always_comb begin
        qual_edge  = 1'b0;
        short_edge = 1'b0;
        unique case (state_q)
            ST_RECESSIVE: ;
            ST_DOM_SHORT: short_edge = txd;
            ST_DOM_LONG:  qual_edge  = txd;
            default: ;
        endcase
    end

    // R2
    qual_after_dom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        qual_edge |-> (!$past(txd) && txd));

    // R2
    short_after_dom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        short_edge |-> !$past(txd));

endmodule

// File: rtl/busflt_chan.sv
module busflt_chan
    import busflt_pkg::*;
#(
    parameter int QUAL_EDGES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic normal_mode,
    input  logic auto_clr,
    input  logic qual_edge,
    input  logic short_edge,
    input  logic raw,
    input  logic w1c,
    input  logic leave_normal,
    output logic flag
);

    localparam int CNT_W = $clog2(QUAL_EDGES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(QUAL_EDGES);

    chan_state_t state_q, state_d;
    logic [CNT_W-1:0] det_q, cln_q;
    logic set_evt, clr_evt, live_edge;

    assign live_edge = normal_mode && qual_edge;

    always_comb begin
        set_evt = live_edge && raw && ((int'(det_q) + 1) >= QUAL_EDGES);
        clr_evt = (w1c && !raw)
               || (auto_clr && leave_normal)
               || (auto_clr && live_edge && !raw && ((int'(cln_q) + 1) >= QUAL_EDGES));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            det_q <= '0;
            cln_q <= '0;
        end else if (!normal_mode || short_edge) begin
            det_q <= '0;
            cln_q <= '0;
        end else if (qual_edge) begin
            if (raw) begin
                det_q <= (det_q == CNT_MAX) ? det_q : det_q + 1'b1;
                cln_q <= '0;
            end else begin
                det_q <= '0;
                cln_q <= (cln_q == CNT_MAX) ? cln_q : cln_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_CLEAR:   if (set_evt) state_d = CH_LATCHED;
            CH_LATCHED: if (clr_evt) state_d = CH_CLEAR;
            default:    state_d = CH_CLEAR;
        endcase
    end

    always_comb begin
        flag = (state_q == CH_LATCHED);
    end

    // R3
    set_on_fault_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(qual_edge && raw && normal_mode));

    // R7
    w1c_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && w1c && raw) |=> flag);

    // R8
    sw_mode_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(flag) && !$past(auto_clr)) |-> $past(w1c && !raw));

endmodule

// File: rtl/busflt_monitor.sv
module busflt_monitor
    import busflt_pkg::*;
#(
    parameter int TICKS_PER_US = 4,
    parameter int MIN_DOM_US   = 2,
    parameter int QUAL_EDGES   = 4,
    parameter int STATUS_W     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 txd,
    input  logic                 normal_mode,
    input  logic                 auto_clr,
    input  logic [FLT_TYPES-1:0] flt_raw,
    input  logic                 wr_en,
    input  logic [STATUS_W-1:0]  wr_data,
    output logic [STATUS_W-1:0]  status,
    output logic                 fault_n
);

    localparam int MIN_DOM_TICKS = TICKS_PER_US * MIN_DOM_US;

    logic qual_edge, short_edge;
    logic normal_q, leave_normal;
    logic [FLT_TYPES-1:0] flags;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            normal_q <= 1'b0;
        end else begin
            normal_q <= normal_mode;
        end
    end

    assign leave_normal = normal_q && !normal_mode;

    busflt_edge_fsm #(
        .MIN_DOM_TICKS(MIN_DOM_TICKS)
    ) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .txd       (txd),
        .qual_edge (qual_edge),
        .short_edge(short_edge)
    );

    for (genvar g = 0; g < FLT_TYPES; g++) begin : g_chan
        busflt_chan #(
            .QUAL_EDGES(QUAL_EDGES)
        ) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .normal_mode (normal_mode),
            .auto_clr    (auto_clr),
            .qual_edge   (qual_edge),
            .short_edge  (short_edge),
            .raw         (flt_raw[g]),
            .w1c         (wr_en && wr_data[g]),
            .leave_normal(leave_normal),
            .flag        (flags[g])
        );
    end

    always_comb begin
        status = '0;
        status[FLT_TYPES-1:0] = flags;
        fault_n = normal_mode ? ~(|flags) : 1'b1;
    end

    // R10
    leave_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(normal_mode) && auto_clr) |=> (status == '0));

endmodule

// File: tb/busflt_monitor_test.sv
module busflt_monitor_test;

    localparam int CLK_PERIOD = 10;
    localparam int TPU = 4;
    localparam int MDU = 2;
    localparam int MIN = TPU * MDU;
    localparam int QE  = 4;
    localparam int NF  = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       txd = 1'b1;
    logic       normal_mode = 1'b0;
    logic       auto_clr = 1'b0;
    logic [4:0] flt_raw = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] status;
    logic       fault_n;

    int checks = 0;
    int errors = 0;
    int dc [NF];
    int cc [NF];
    bit fl [NF];
    bit m_norm = 0;
    bit m_auto = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    busflt_monitor #(.TICKS_PER_US(TPU), .MIN_DOM_US(MDU), .QUAL_EDGES(QE), .STATUS_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .txd(txd), .normal_mode(normal_mode),
        .auto_clr(auto_clr), .flt_raw(flt_raw), .wr_en(wr_en), .wr_data(wr_data),
        .status(status), .fault_n(fault_n)
    );

    function automatic logic [7:0] exp_status();
        logic [7:0] s = '0;
        for (int i = 0; i < NF; i++) s[i] = fl[i];
        return s;
    endfunction

    function automatic logic exp_fault_n();
        return !(m_norm && (exp_status() != 8'h00));
    endfunction

    task automatic check(string req);
        checks++;
        if (status !== exp_status() || fault_n !== exp_fault_n()) begin
            errors++;
            $display("FAIL %s status=%h fault_n=%b expected status=%h fault_n=%b",
                     req, status, fault_n, exp_status(), exp_fault_n());
        end
    endtask

    function automatic void model_edge(int len, logic [4:0] f);
        if (!m_norm) return;
        for (int i = 0; i < NF; i++) begin
            if (len < MIN) begin
                dc[i] = 0; cc[i] = 0;
            end else if (f[i]) begin
                dc[i] = (dc[i] < QE) ? dc[i] + 1 : QE;
                cc[i] = 0;
                if (dc[i] >= QE) fl[i] = 1;
            end else begin
                dc[i] = 0;
                cc[i] = (cc[i] < QE) ? cc[i] + 1 : QE;
                if (m_auto && cc[i] >= QE) fl[i] = 0;
            end
        end
    endfunction

    // one dominant bit of len cycles followed by recessive, check after the edge
    task automatic send_bit(int len, logic [4:0] f, string req);
        @(negedge clk);
        flt_raw = f;
        txd = 1'b0;
        repeat (len) @(negedge clk);
        txd = 1'b1;
        @(negedge clk);
        model_edge(len, f);
        check(req);
    endtask

    task automatic write_clr(logic [7:0] d, logic [4:0] f, string req);
        @(negedge clk);
        flt_raw = f;
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = '0;
        for (int i = 0; i < NF; i++) if (d[i] && !f[i]) fl[i] = 0;
        check(req);
    endtask

    task automatic set_normal(bit v, string req);
        @(negedge clk);
        if (m_norm && !v && m_auto) for (int i = 0; i < NF; i++) fl[i] = 0;
        if (!v) for (int i = 0; i < NF; i++) begin dc[i] = 0; cc[i] = 0; end
        m_norm = v;
        normal_mode = v;
        @(negedge clk);
        check(req);
    endtask

    task automatic set_auto(bit v);
        @(negedge clk);
        m_auto = v;
        auto_clr = v;
        @(negedge clk);
    endtask

    task automatic latch(logic [4:0] f, string req);
        for (int k = 0; k < QE; k++) send_bit(MIN + 2, f, req);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NF; i++) begin dc[i] = 0; cc[i] = 0; fl[i] = 0; end
        repeat (3) @(negedge clk);
        check("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release");
        set_normal(1, "R11 enter normal");

        // R3: three edges are not enough, the fourth sets the flag
        for (int k = 0; k < 3; k++) send_bit(MIN, 5'b00001, "R3 below threshold");
        send_bit(MIN, 5'b00001, "R3 fourth edge sets");
        // R7: clear blocked while raw present
        write_clr(8'h01, 5'b00001, "R7 blocked clear");
        // R6: zero bits no effect, one bit clears
        write_clr(8'hFE, 5'b00000, "R6 zero bit ignored");
        write_clr(8'h01, 5'b00000, "R6 clear accepted");

        // R2: short dominant restarts progress
        for (int k = 0; k < 3; k++) send_bit(MIN, 5'b00010, "R2 long edges");
        send_bit(MIN - 1, 5'b00010, "R2 short edge restarts");
        send_bit(MIN, 5'b00010, "R2 after restart no set");
        for (int k = 0; k < 2; k++) send_bit(MIN, 5'b00010, "R2 progress");
        send_bit(MIN, 5'b00010, "R2 fourth long edge sets");
        write_clr(8'h02, 5'b00000, "R6 clear bit1");

        // R4: clean edge restarts count
        for (int k = 0; k < 3; k++) send_bit(MIN + 1, 5'b00100, "R4 count");
        send_bit(MIN + 1, 5'b00000, "R4 clean restarts");
        for (int k = 0; k < 3; k++) send_bit(MIN + 1, 5'b00100, "R4 no set yet");
        write_clr(8'h04, 5'b00000, "R4 cleanup");

        // R5: each position
        latch(5'b01000, "R5 bit3 CANH ground");
        latch(5'b10000, "R5 bit4 CANH-CANL");
        write_clr(8'hFF, 5'b00000, "R5 clear all");

        // R8: software mode holds through clean edges and leaving normal
        latch(5'b00001, "R8 latch");
        for (int k = 0; k < 5; k++) send_bit(MIN, 5'b00000, "R8 no auto clear");
        set_normal(0, "R8 leave normal holds, R11 fault_n high");
        send_bit(MIN, 5'b00001, "R12 edge outside normal");
        set_normal(1, "R11 flag visible again");
        write_clr(8'h01, 5'b00000, "R8 software clear");

        // R12: progress outside normal mode is discarded
        for (int k = 0; k < 3; k++) send_bit(MIN, 5'b00100, "R12 count");
        set_normal(0, "R12 leave");
        set_normal(1, "R12 reenter");
        send_bit(MIN, 5'b00100, "R12 restart no set");

        // R9: auto clear after clean run
        set_auto(1);
        latch(5'b10001, "R9 latch");
        for (int k = 0; k < 3; k++) send_bit(MIN, 5'b00000, "R9 three clean keep");
        send_bit(MIN, 5'b00000, "R9 fourth clean clears");
        // R10: leaving normal clears in auto mode
        latch(5'b01000, "R10 latch");
        set_normal(0, "R10 leave clears");
        set_normal(1, "R10 reenter");
        set_auto(0);

        // random mix
        for (int it = 0; it < 400; it++) begin
            int op = $urandom_range(0, 9);
            logic [4:0] f = ($urandom_range(0, 3) == 0) ? 5'b0 : 5'($urandom_range(0, 31));
            if (op < 6) begin
                int sel = $urandom_range(0, 4);
                int len = (sel == 0) ? 2 : (sel == 1) ? MIN - 1 : (sel == 2) ? MIN : MIN + 5;
                send_bit(len, f, "R3 random edge");
            end else if (op < 8) begin
                write_clr(8'($urandom_range(0, 255)), f, "R6 random write");
            end else if (op == 8) begin
                set_normal(!m_norm, "R10 random mode");
            end else begin
                set_auto(!m_auto);
                check("R9 random policy");
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule